// File: doc/BRIEF.md
# Interleaved Multiphase PWM Generator

This block drives the switch commands of a boost converter with two, three or four power stages that share one switching period. A free-running tick counter defines the period, which is `12*UNIT` clock cycles long. Each active stage gets a pulse that starts at its own offset, and the offsets are spread evenly across the period. Each pulse ends at whichever comes first: the commanded on-time, a current-trip flag for that stage, or a maximum-duty clamp chosen by a select input. Because the stages are staggered, the combined ripple runs at the phase count times the switching rate.

A second controller can be chained to this one through a square-wave clock output. That output rises in the same cycle as the leading edge of the first stage's pulse. An output polarity option suits drivers of either sense. When the third idle level is enabled, an output-enable per stage is released while that stage is switched off, so the pin can be held at a mid level. Straps set the phase count once, when reset is released. The clamp select, polarity and idle mode are taken at the start of the master period. Each stage takes its on-time and enable at the start of its own period, so a change to any input cannot cut a pulse short or stretch it.

Top module: `mpwm_interleave`

## Requirements
- R1: At the first clock edge after reset release, the straps set the phase count N. `cnt2_strap_i`=1 gives N=2, and this takes priority. Otherwise `cnt3_strap_i`=1 gives N=3. Otherwise N=4. Stages with index N or higher never pulse.
- R2: Stage k (k<N) pulses when (tick − k·P/N) mod P < width, where P = 12·UNIT and tick is the master count. Stage 0's pulse starts in the cycle after master tick 0.
- R3: Pulse width in cycles = min(duty, clamp). A duty of 0 produces no pulse. A duty at or above the clamp gives exactly the clamp.
- R4: The clamp codes on `clamp_sel_i` are: 2'b00 gives 11·UNIT (11/12 of P), 2'b10 gives 10·UNIT, and 2'b01 or 2'b11 gives 9·UNIT.
- R5: A trip bit that is high at a clock edge takes that stage low from the next cycle. The stage stays low until its next period starts. A trip at the stage's start edge suppresses the whole pulse.
- R6: The duty value and the stage's `phase_en_i` bit are sampled only at that stage's start edge. Changes during the period do not affect the pulse in flight.
- R7: `chain_clk_o` is high for the first P/2 cycles of each master period, so consecutive rising edges are exactly P cycles apart. Its rising edge falls in the same cycle as stage 0's leading edge.
- R8: `pol_inv_i` is sampled at master tick 0. While the sampled value is 1, every `pwm_o` bit is the complement of its pulse. An idle stage then sits at 1.
- R9: `idle_mid_en_i` is sampled at master tick 0. While it is 1, `pwm_oe_o[k]` is 0 for each stage that is disabled, meaning its sampled enable is 0 or k≥N. While it is 0, all `pwm_oe_o` bits are 1.
- R10: While reset is held, `pwm_o`=0, `pwm_oe_o`=all ones and `chain_clk_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_i | input | $clog2(12*UNIT+1) | Commanded on-time in ticks |
| trip_i | input | 4 | Per-stage current-trip flags |
| cnt2_strap_i | input | 1 | Strap: two-stage operation |
| cnt3_strap_i | input | 1 | Strap: three-stage operation |
| clamp_sel_i | input | 2 | Maximum-duty clamp select |
| pol_inv_i | input | 1 | Invert all PWM outputs |
| idle_mid_en_i | input | 1 | Enable mid-level idle for disabled stages |
| phase_en_i | input | 4 | Per-stage enable mask |
| pwm_o | output | 4 | PWM commands, stage 0 in bit 0 |
| pwm_oe_o | output | 4 | Per-stage output enable (0 = mid-level idle) |
| chain_clk_o | output | 1 | Square-wave clock for a chained controller |

## Verification
The hardest conditions to reach from the ports are a trip, or a duty change, that lands on the exact edge where one specific stage starts its period. The other is a change that arrives while a pulse wraps across the master period boundary. The bench keeps its own count of master ticks from reset release. It aims trips and duty changes at chosen stage offsets using that count. A pseudo-random sweep of duty, mask and sparse trips, changing every few cycles, covers the wrap-around and mid-pulse cases.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
  localparam int unsigned MAX_STAGES = 4;

  // phase-count straps: the two-stage strap wins over the three-stage one
  function automatic logic [2:0] strap_count(input logic two_st, input logic three_st);
    if (two_st) return 3'd2;
    else if (three_st) return 3'd3;
    else return 3'd4;
  endfunction

  // clamp select to twelfths of a period
  function automatic int unsigned clamp_twelfths(input logic [1:0] sel);
    case (sel)
      2'b00:   return 11;
      2'b10:   return 10;
      default: return 9;
    endcase
  endfunction
endpackage

// File: rtl/mpwm_timebase.sv
module mpwm_timebase #(
  parameter int unsigned PERIOD = 48,
  parameter int unsigned DW     = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-1:0] tick,
  output logic          start,
  output logic          chain_clk
);
  localparam logic [DW-1:0] LAST = DW'(PERIOD - 1);
  localparam logic [DW-1:0] HALF = DW'(PERIOD / 2);

  assign start = (tick == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick      <= '0;
      chain_clk <= 1'b0;
    end else begin
      tick      <= (tick == LAST) ? '0 : tick + 1'b1;
      chain_clk <= (tick < HALF);
    end
  end
endmodule

// File: rtl/mpwm_cfg.sv
module mpwm_cfg
  import mpwm_pkg::*;
#(
  parameter int unsigned UNIT = 4,
  parameter int unsigned DW   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cnt2_strap,
  input  logic          cnt3_strap,
  input  logic [1:0]    clamp_sel,
  input  logic          pol_inv,
  input  logic          idle_mid_en,
  output logic [2:0]    nph,
  output logic [DW-1:0] clamp,
  output logic          inv_q,
  output logic          tri_q
);
  logic          taken_q;
  logic [2:0]    nph_q;
  logic [DW-1:0] clamp_q;
  logic [DW-1:0] clamp_new;

  assign clamp_new = DW'(clamp_twelfths(clamp_sel) * UNIT);
  // current values: the ones being sampled at this edge, else the held ones
  assign nph   = taken_q ? nph_q : strap_count(cnt2_strap, cnt3_strap);
  assign clamp = start ? clamp_new : clamp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q <= 1'b0;
      nph_q   <= 3'd4;
      clamp_q <= DW'(9 * UNIT);
      inv_q   <= 1'b0;
      tri_q   <= 1'b0;
    end else begin
      if (!taken_q) begin
        taken_q <= 1'b1;
        nph_q   <= nph;
      end
      if (start) begin
        clamp_q <= clamp_new;
        inv_q   <= pol_inv;
        tri_q   <= idle_mid_en;
      end
    end
  end
endmodule

// File: rtl/mpwm_phase.sv
module mpwm_phase #(
  parameter int unsigned PERIOD = 48,
  parameter int unsigned DW     = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] tick,
  input  logic [DW-1:0] offset,
  input  logic [DW-1:0] clamp,
  input  logic [DW-1:0] duty,
  input  logic          en_new,
  input  logic          trip,
  output logic          hi,
  output logic          en_q
);
  logic [DW-1:0] pos;
  logic [DW-1:0] on_q;
  logic [DW-1:0] on_new;

  // position inside this stage's own period; modular wrap is exact below 2**DW
  assign pos    = (tick >= offset) ? (tick - offset) : (tick - offset + DW'(PERIOD));
  assign on_new = (duty < clamp) ? duty : clamp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi   <= 1'b0;
      en_q <= 1'b0;
      on_q <= '0;
    end else if (pos == '0) begin
      on_q <= on_new;
      en_q <= en_new;
      hi   <= en_new && (on_new != '0) && !trip;
    end else if (trip || (pos == on_q)) begin
      hi <= 1'b0;
    end
  end
endmodule

// File: rtl/mpwm_interleave.sv
module mpwm_interleave
  import mpwm_pkg::*;
#(
  parameter  int unsigned UNIT   = 4,
  localparam int unsigned PERIOD = 12 * UNIT,
  localparam int unsigned DW     = $clog2(PERIOD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] duty_i,
  input  logic [3:0]    trip_i,
  input  logic          cnt2_strap_i,
  input  logic          cnt3_strap_i,
  input  logic [1:0]    clamp_sel_i,
  input  logic          pol_inv_i,
  input  logic          idle_mid_en_i,
  input  logic [3:0]    phase_en_i,
  output logic [3:0]    pwm_o,
  output logic [3:0]    pwm_oe_o,
  output logic          chain_clk_o
);
  localparam int unsigned STEP2 = PERIOD / 2;
  localparam int unsigned STEP3 = PERIOD / 3;
  localparam int unsigned STEP4 = PERIOD / 4;

  logic [DW-1:0]         tick;
  logic                  start;
  logic [2:0]            nph;
  logic [DW-1:0]         clamp;
  logic                  inv_q;
  logic                  tri_q;
  logic [MAX_STAGES-1:0] phase_hi;
  logic [MAX_STAGES-1:0] phase_en_q;

  mpwm_timebase #(.PERIOD(PERIOD), .DW(DW)) u_timebase (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .chain_clk(chain_clk_o)
  );

  mpwm_cfg #(.UNIT(UNIT), .DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cnt2_strap(cnt2_strap_i), .cnt3_strap(cnt3_strap_i),
    .clamp_sel(clamp_sel_i), .pol_inv(pol_inv_i), .idle_mid_en(idle_mid_en_i),
    .nph(nph), .clamp(clamp), .inv_q(inv_q), .tri_q(tri_q)
  );

  for (genvar g = 0; g < MAX_STAGES; g++) begin : g_stage
    logic          active;
    logic [DW-1:0] offset;
    int unsigned   step;

    assign active = (int'(nph) > g);

    always_comb begin
      case (nph)
        3'd2:    step = STEP2;
        3'd3:    step = STEP3;
        default: step = STEP4;
      endcase
      offset = active ? DW'(g * step) : '0;
    end

    mpwm_phase #(.PERIOD(PERIOD), .DW(DW)) u_phase (
      .clk(clk), .rst_n(rst_n), .tick(tick), .offset(offset), .clamp(clamp),
      .duty(duty_i), .en_new(phase_en_i[g] && active), .trip(trip_i[g]),
      .hi(phase_hi[g]), .en_q(phase_en_q[g])
    );

    assign pwm_o[g]    = phase_hi[g] ^ inv_q;
    assign pwm_oe_o[g] = !tri_q || phase_en_q[g];
  end
endmodule

// File: rtl/mpwm_chk.sv
module mpwm_chk #(
  parameter int unsigned UNIT = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] trip,
  input logic [3:0] hi,
  input logic [3:0] pwm,
  input logic [3:0] oe,
  input logic       clk_out,
  input logic       inv_q,
  input logic       tri_q
);
  localparam int unsigned PERIOD = 12 * UNIT;
  localparam int unsigned MAXON  = 11 * UNIT;

  logic        ck_d;
  logic        seen;
  logic [15:0] gap;
  logic        rise;

  assign rise = clk_out && !ck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_d <= 1'b0;
      seen <= 1'b0;
      gap  <= '0;
    end else begin
      ck_d <= clk_out;
      if (rise) begin
        gap  <= 16'd1;
        seen <= 1'b1;
      end else if (gap != 16'hFFFF) begin
        gap <= gap + 16'd1;
      end
    end
  end

  // R7
  clk_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && seen) |-> (gap == 16'(PERIOD)));

  // R7
  clk_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi[0]) |-> $rose(clk_out));

  // R9
  oe_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tri_q |-> (oe == 4'hF));

  for (genvar k = 0; k < 4; k++) begin : g_k
    logic [15:0] run;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run <= '0;
      else        run <= hi[k] ? run + 16'd1 : '0;
    end

    // R5
    trip_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trip[k] |=> !hi[k]);

    // R3
    width_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hi[k] |-> (run < 16'(MAXON)));

    // R9
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !oe[k] |-> (pwm[k] == inv_q));
  end
endmodule

bind mpwm_interleave mpwm_chk #(.UNIT(UNIT)) u_mpwm_chk (
  .clk(clk), .rst_n(rst_n), .trip(trip_i), .hi(phase_hi), .pwm(pwm_o),
  .oe(pwm_oe_o), .clk_out(chain_clk_o), .inv_q(inv_q), .tri_q(tri_q)
);

// File: tb/test_mpwm_interleave.sv
module test_mpwm_interleave;
  localparam int UNIT = 2;
  localparam int P    = 12 * UNIT;
  localparam int DW   = $clog2(P + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] duty_i = '0;
  logic [3:0]    trip_i = '0;
  logic          cnt2_strap_i = 1'b0;
  logic          cnt3_strap_i = 1'b0;
  logic [1:0]    clamp_sel_i = 2'b00;
  logic          pol_inv_i = 1'b0;
  logic          idle_mid_en_i = 1'b0;
  logic [3:0]    phase_en_i = 4'hF;
  logic [3:0]    pwm_o;
  logic [3:0]    pwm_oe_o;
  logic          chain_clk_o;

  always #5 clk = ~clk;

  mpwm_interleave #(.UNIT(UNIT)) i_mpwm_interleave (
    .clk(clk), .rst_n(rst_n), .duty_i(duty_i), .trip_i(trip_i),
    .cnt2_strap_i(cnt2_strap_i), .cnt3_strap_i(cnt3_strap_i),
    .clamp_sel_i(clamp_sel_i), .pol_inv_i(pol_inv_i),
    .idle_mid_en_i(idle_mid_en_i), .phase_en_i(phase_en_i),
    .pwm_o(pwm_o), .pwm_oe_o(pwm_oe_o), .chain_clk_o(chain_clk_o)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  bit    cmp_en = 1'b0;
  string cur_req = "R3";

  // arithmetic reference, advanced at each rising edge
  int mc, mn, ml;
  bit mtaken, minv, mtri, mclk;
  int mon [4];
  bit mhi [4];
  bit men [4];

  always @(posedge clk) begin : model
    int n, l, o, p, on;
    bit en;
    if (!rst_n) begin
      mc <= 0; mtaken <= 1'b0; mn <= 4; ml <= 9 * UNIT;
      minv <= 1'b0; mtri <= 1'b0; mclk <= 1'b0;
      for (int k = 0; k < 4; k++) begin mon[k] <= 0; mhi[k] <= 1'b0; men[k] <= 1'b0; end
    end else begin
      n = mtaken ? mn : (cnt2_strap_i ? 2 : (cnt3_strap_i ? 3 : 4));
      if (!mtaken) begin mn <= n; mtaken <= 1'b1; end
      l = (clamp_sel_i == 2'b00) ? 11 * UNIT : ((clamp_sel_i == 2'b10) ? 10 * UNIT : 9 * UNIT);
      if (mc != 0) l = ml;
      if (mc == 0) begin ml <= l; minv <= pol_inv_i; mtri <= idle_mid_en_i; end
      for (int k = 0; k < 4; k++) begin
        o  = (k < n) ? (k * P) / n : 0;
        p  = (mc - o + P) % P;
        en = phase_en_i[k] && (k < n);
        on = (int'(duty_i) < l) ? int'(duty_i) : l;
        if (p == 0) begin
          mon[k] <= on; men[k] <= en;
          mhi[k] <= en && (on > 0) && !trip_i[k];
        end else if (trip_i[k] || p == mon[k]) begin
          mhi[k] <= 1'b0;
        end
      end
      mclk <= (mc < P / 2);
      mc   <= (mc + 1) % P;
    end
  end

  task automatic check(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [3:0] ep, eo;
    if (rst_n && cmp_en) begin
      for (int k = 0; k < 4; k++) begin
        ep[k] = mhi[k] ^ minv;
        eo[k] = !mtri || men[k];
      end
      check(cur_req, "pwm_o", pwm_o, ep);
      check("R9", "pwm_oe_o", pwm_oe_o, eo);
      check("R7", "chain_clk_o", {3'b0, chain_clk_o}, {3'b0, mclk});
    end
  end

  task automatic do_reset(input logic two_st, input logic three_st);
    @(negedge clk);
    rst_n = 1'b0;
    cnt2_strap_i = two_st;
    cnt3_strap_i = three_st;
    trip_i = '0;
    repeat (3) begin
      @(negedge clk);
      // R10 reset state
      check("R10", "pwm_o in reset", pwm_o, 4'h0);
      check("R10", "pwm_oe_o in reset", pwm_oe_o, 4'hF);
      check("R10", "chain_clk_o in reset", {3'b0, chain_clk_o}, 4'h0);
    end
    rst_n = 1'b1;
    cmp_en = 1'b1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] lf;
    lf = 16'hACE1;

    // R1 R2 R3 R4: every strap pair, clamp code and duty value
    for (int s = 0; s < 4; s++) begin
      do_reset(s[1], s[0]);
      phase_en_i = 4'hF; pol_inv_i = 1'b0; idle_mid_en_i = 1'b0;
      for (int c = 0; c < 4; c++) begin
        clamp_sel_i = 2'(c);
        for (int d = 0; d <= P; d++) begin
          cur_req = "R1 R2 R3 R4";
          duty_i = DW'(d);
          repeat (2 * P) @(negedge clk);
        end
      end
    end

    // R6: duty and mask change at odd moments, including mid-pulse
    do_reset(1'b0, 1'b0);
    clamp_sel_i = 2'b00;
    cur_req = "R6";
    for (int i = 0; i < 400; i++) begin
      if (i % 5 == 0) duty_i = DW'((i * 7) % (P + 1));
      if (i % 11 == 0) phase_en_i = 4'((i * 3) % 16);
      @(negedge clk);
    end

    // R5: trip aimed at stage 1 start edge, then mid-pulse, then sparse random trips
    phase_en_i = 4'hF; duty_i = DW'(P);
    cur_req = "R5";
    repeat (2 * P) @(negedge clk);
    while (mc != P / 4) @(negedge clk);
    trip_i = 4'b0010;
    @(negedge clk);
    trip_i = '0;
    repeat (P) @(negedge clk);
    while (mc != 5) @(negedge clk);
    trip_i = 4'b0001;
    @(negedge clk);
    trip_i = '0;
    repeat (2 * P) @(negedge clk);
    for (int i = 0; i < 800; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      trip_i = lf[3:0] & lf[7:4] & lf[11:8];
      if (i % 13 == 0) duty_i = DW'((i * 5) % (P + 1));
      @(negedge clk);
    end
    trip_i = '0;

    // R8 R9: polarity and idle mode over every mask, three-stage straps
    do_reset(1'b0, 1'b1);
    duty_i = DW'(P / 3);
    for (int v = 0; v < 4; v++) begin
      pol_inv_i = v[0];
      idle_mid_en_i = v[1];
      for (int m = 0; m < 16; m++) begin
        cur_req = "R8 R9";
        phase_en_i = 4'(m);
        repeat (2 * P) @(negedge clk);
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule